// File: doc/BRIEF.md
# Two-Level Multi-Queue Request Arbiter

Each input port of a crosspoint switch may offer several candidate outputs at once, one for each of its queues. The input is content with any one of them. This arbiter takes such a request and resolves it in two word clocks. In the first word clock it reserves every candidate output that is neither busy nor reserved elsewhere. In the second word clock it keeps one of those outputs as the winner and frees the rest.

A request that reserves nothing stays latched and is tried again on every word clock. It leaves only when it is granted or when a packet header word is seen on its input. The number of the granted output goes back to the port card as a one-cycle grant. It is also sent over a two-bit overhead lane in two consecutive words, high half first.

Requests without the multi-queue flag are not handled here. They belong to the ordinary single-output path. `N_OUT` must be a power of two with an even number of index bits.

Top module: `mq_arbiter`

## Requirements
- R1: A request whose multi-queue flag is 0 is not latched and never produces a grant.
- R2: In the first level, an input holds every candidate output that is free. Free means its `out_busy` bit is 0 and no input currently in the second level holds it. Busy outputs are not held.
- R3: In the second level, the winner is the first held output found by searching upward from the input's pointer, wrapping modulo `N_OUT`. The pointer is reset to 0 and becomes winner+1 after each grant. All held outputs are released at the end of that word clock.
- R4: No output is held by two inputs at once. When two inputs want the same free output in the same first-level evaluation, the lower-numbered input takes it.
- R5: An output released by the second level can be held by another input in the first-level evaluation of the very next word clock.
- R6: A request that held nothing stays pending. It is evaluated again on every word clock until it wins.
- R7: While `hdr_seen` of an input is 1, that input's pending request is dropped at the next edge. It takes no part in the first level. If it is in the second level during that cycle, it produces no grant.
- R8: A grant appears three clock edges after the request is presented. Edge 1 latches the request, edge 2 holds outputs, and edge 3 raises `grant_valid` for one cycle with `grant_port` set to the winner.
- R9: In the grant cycle, `oh_strobe` is 1 and `oh_bits` carries the upper half of the port number. In the next cycle, `oh_strobe` is 0 and `oh_bits` carries the lower half. Otherwise `oh_bits` is 0.
- R10: After reset, `grant_valid`, `oh_strobe` and `oh_bits` are 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_IN | Request present on an input, one bit per input |
| req_multi | input | N_IN | Multi-queue flag of each request |
| req_mask | input | N_IN x N_OUT | Candidate outputs of each input |
| hdr_seen | input | N_IN | Packet header word seen on an input |
| out_busy | input | N_OUT | Outputs already connected elsewhere |
| grant_valid | output | N_IN | One-cycle grant pulse per input |
| grant_port | output | N_IN x log2(N_OUT) | Granted output number per input |
| oh_bits | output | N_IN x log2(N_OUT)/2 | Overhead lane carrying the port number |
| oh_strobe | output | N_IN | Marks the first (upper) overhead chunk |

## Verification
Two functions can fall in the same cycle. A header pulse can arrive in the very word clock in which that input's second level would choose a winner. A release by one input can also coincide with another input's retry of the same output. The bench raises `hdr_seen` exactly in the second-level cycle and expects no grant at the next edge. It then sends two inputs at one output in the same cycle and expects the lower one to win at edge 3 and the other at edge 5. A third case has the loser competing only for an output its neighbour frees as a non-winner.

// File: rtl/mq_arbiter.sv
module mq_arbiter #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 16,
  localparam int PW   = $clog2(N_OUT),
  localparam int HW   = PW / 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_IN-1:0]               req_valid,
  input  logic [N_IN-1:0]               req_multi,
  input  logic [N_IN-1:0][N_OUT-1:0]    req_mask,
  input  logic [N_IN-1:0]               hdr_seen,
  input  logic [N_OUT-1:0]              out_busy,
  output logic [N_IN-1:0]               grant_valid,
  output logic [N_IN-1:0][PW-1:0]       grant_port,
  output logic [N_IN-1:0][HW-1:0]       oh_bits,
  output logic [N_IN-1:0]               oh_strobe
);

  logic [N_IN-1:0]            pend;
  logic [N_IN-1:0][N_OUT-1:0] want;
  logic [N_IN-1:0][N_OUT-1:0] hold;
  logic [N_IN-1:0][N_OUT-1:0] avail;
  logic [N_IN-1:0][PW-1:0]    ptr;
  logic [N_IN-1:0][HW-1:0]    low_q;
  logic [N_IN-1:0]            low_pend;
  logic [N_OUT-1:0]           held_any;
  logic [N_OUT-1:0]           claimed;
  logic                       has_win [N_IN];
  logic [PW-1:0]              win     [N_IN];

  always_comb begin
    held_any = '0;
    for (int i = 0; i < N_IN; i++) held_any |= hold[i];
  end

  always_comb begin
    claimed = held_any;
    for (int i = 0; i < N_IN; i++) begin
      avail[i] = '0;
      if (pend[i] && hold[i] == '0 && !hdr_seen[i]) begin
        avail[i] = want[i] & ~out_busy & ~claimed;
        claimed  = claimed | avail[i];
      end
    end
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_pick
    always_comb begin : pick
      logic [PW-1:0] idx;
      has_win[g] = 1'b0;
      win[g]     = '0;
      for (int k = 0; k < N_OUT; k++) begin
        idx = ptr[g] + PW'(k);
        if (!has_win[g] && hold[g][idx]) begin
          has_win[g] = 1'b1;
          win[g]     = idx;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend        <= '0;
      want        <= '0;
      hold        <= '0;
      ptr         <= '0;
      grant_valid <= '0;
      grant_port  <= '0;
      oh_bits     <= '0;
      oh_strobe   <= '0;
      low_q       <= '0;
      low_pend    <= '0;
    end else begin
      for (int i = 0; i < N_IN; i++) begin
        grant_valid[i] <= 1'b0;
        oh_strobe[i]   <= 1'b0;
        low_pend[i]    <= 1'b0;
        oh_bits[i]     <= low_pend[i] ? low_q[i] : '0;
        if (hdr_seen[i]) begin
          pend[i] <= 1'b0;
          hold[i] <= '0;
        end else if (hold[i] != '0) begin
          hold[i] <= '0;
          if (has_win[i]) begin
            pend[i]        <= 1'b0;
            ptr[i]         <= win[i] + 1'b1;
            grant_valid[i] <= 1'b1;
            grant_port[i]  <= win[i];
            oh_strobe[i]   <= 1'b1;
            oh_bits[i]     <= win[i][PW-1:HW];
            low_q[i]       <= win[i][HW-1:0];
            low_pend[i]    <= 1'b1;
          end
        end else begin
          hold[i] <= avail[i];
          if (!pend[i] && req_valid[i] && req_multi[i]) begin
            pend[i] <= 1'b1;
            want[i] <= req_mask[i];
          end
        end
      end
    end
  end

endmodule

// File: rtl/mq_arbiter_chk.sv
module mq_arbiter_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 16,
  localparam int PW   = $clog2(N_OUT),
  localparam int HW   = PW / 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_IN-1:0]            hdr_seen,
  input logic [N_OUT-1:0]           out_busy,
  input logic [N_IN-1:0][N_OUT-1:0] hold,
  input logic [N_IN-1:0]            grant_valid,
  input logic [N_IN-1:0][PW-1:0]    grant_port,
  input logic [N_IN-1:0][HW-1:0]    oh_bits,
  input logic [N_IN-1:0]            oh_strobe
);

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    a_r2_hold_free: assert property (@(posedge clk) disable iff (!rst_n)
      (hold[i] != '0) |-> (($past(out_busy) & hold[i]) == '0));

    a_r8_grant_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid[i] |-> (|($past(hold[i]) & (N_OUT'(1) << grant_port[i]))));

    a_r7_hdr_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_seen[i] |=> !grant_valid[i]);

    a_r9_high_chunk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid[i] |-> (oh_strobe[i] && oh_bits[i] == grant_port[i][PW-1:HW]));

    a_r9_low_chunk: assert property (@(posedge clk) disable iff (!rst_n)
      oh_strobe[i] |=> (!oh_strobe[i] && oh_bits[i] == $past(grant_port[i][HW-1:0])));

    for (genvar j = i + 1; j < N_IN; j++) begin : g_pair
      a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (hold[i] & hold[j]) == '0);
    end
  end

endmodule

bind mq_arbiter mq_arbiter_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_seen(hdr_seen), .out_busy(out_busy),
  .hold(hold), .grant_valid(grant_valid), .grant_port(grant_port),
  .oh_bits(oh_bits), .oh_strobe(oh_strobe)
);

// File: tb/mq_arbiter_tb.sv
module mq_arbiter_tb;
  localparam int N_IN = 4, N_OUT = 16, PW = 4, HW = 2;

  logic clk = 0, rst_n = 0;
  logic [N_IN-1:0] req_valid = '0, req_multi = '0, hdr_seen = '0;
  logic [N_IN-1:0][N_OUT-1:0] req_mask = '0;
  logic [N_OUT-1:0] out_busy = '0;
  logic [N_IN-1:0] grant_valid, oh_strobe;
  logic [N_IN-1:0][PW-1:0] grant_port;
  logic [N_IN-1:0][HW-1:0] oh_bits;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mq_arbiter #(.N_IN(N_IN), .N_OUT(N_OUT)) u_dut (.*);

  // {candidates, busy, expected winner} for input 0, pointer carried from reset
  localparam logic [35:0] VEC [8] = '{
    {16'h0011, 16'h0000, 4'd0},
    {16'h0011, 16'h0000, 4'd4},
    {16'h0011, 16'h0000, 4'd0},
    {16'h8100, 16'h0100, 4'd15},
    {16'h00F0, 16'h0030, 4'd6},
    {16'h00F0, 16'h0000, 4'd7},
    {16'h0A00, 16'h0000, 4'd9},
    {16'h0003, 16'h0000, 4'd0}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int i, logic [N_OUT-1:0] m, logic multi);
    req_mask[i] = m; req_multi[i] = multi; req_valid[i] = 1'b1;
  endtask

  initial begin
    step(3);
    chk("R10 grant_valid", int'(grant_valid), 0);
    chk("R10 oh_strobe", int'(oh_strobe), 0);
    chk("R10 oh_bits", int'(oh_bits), 0);
    rst_n = 1;
    step(2);

    foreach (VEC[v]) begin
      send(0, VEC[v][35:20], 1'b1);
      out_busy = VEC[v][19:4];
      step(1); req_valid = '0;
      step(1);
      chk("R10 no pending leak before edge 3", int'(grant_valid[0]), 0);
      step(1);
      chk("R8 grant pulse", int'(grant_valid[0]), 1);
      chk("R3 R2 winner", int'(grant_port[0]), int'(VEC[v][3:0]));
      chk("R9 strobe", int'(oh_strobe[0]), 1);
      chk("R9 high chunk", int'(oh_bits[0]), int'(VEC[v][3:2]));
      step(1);
      chk("R8 single pulse", int'(grant_valid[0]), 0);
      chk("R9 low chunk", int'(oh_bits[0]), int'(VEC[v][1:0]));
      chk("R9 strobe low", int'(oh_strobe[0]), 0);
      out_busy = '0;
      step(1);
      chk("R9 idle lane", int'(oh_bits[0]), 0);
    end

    // R1: single-queue request ignored
    send(0, 16'h0002, 1'b0);
    step(1); req_valid = '0;
    for (int k = 0; k < 5; k++) begin
      chk("R1 no grant", int'(grant_valid[0]), 0);
      step(1);
    end

    // R6: blocked request retried
    send(1, 16'h0004, 1'b1); out_busy = 16'h0004;
    step(1); req_valid = '0;
    for (int k = 0; k < 6; k++) begin
      step(1);
      chk("R6 blocked", int'(grant_valid[1]), 0);
    end
    out_busy = '0;
    step(2);
    chk("R6 retry grant", int'(grant_valid[1]), 1);
    chk("R6 retry port", int'(grant_port[1]), 2);
    step(3);

    // R7: header while blocked
    send(2, 16'h0040, 1'b1); out_busy = 16'h0040;
    step(1); req_valid = '0;
    step(1); hdr_seen[2] = 1'b1;
    step(1); hdr_seen[2] = 1'b0; out_busy = '0;
    for (int k = 0; k < 5; k++) begin
      step(1);
      chk("R7 cancelled while blocked", int'(grant_valid[2]), 0);
    end

    // R7: header in the second-level cycle
    send(2, 16'h0040, 1'b1);
    step(1); req_valid = '0;
    step(1); hdr_seen[2] = 1'b1;
    step(1); hdr_seen[2] = 1'b0;
    chk("R7 cancelled at selection", int'(grant_valid[2]), 0);
    for (int k = 0; k < 4; k++) begin
      step(1);
      chk("R7 stays cancelled", int'(grant_valid[2]), 0);
    end

    // R4: same output, same cycle
    send(0, 16'h0008, 1'b1); send(1, 16'h0008, 1'b1);
    step(1); req_valid = '0;
    step(2);
    chk("R4 low input wins", int'(grant_valid[0]), 1);
    chk("R4 port", int'(grant_port[0]), 3);
    chk("R4 high input waits", int'(grant_valid[1]), 0);
    step(1);
    chk("R4 still waiting", int'(grant_valid[1]), 0);
    step(1);
    chk("R5 loser gets released output", int'(grant_valid[1]), 1);
    chk("R5 port", int'(grant_port[1]), 3);
    step(3);

    // R5: non-winner release reused next evaluation
    send(0, 16'h0030, 1'b1); send(1, 16'h0020, 1'b1);
    step(1); req_valid = '0;
    step(2);
    chk("R3 winner from pointer", int'(grant_port[0]), 4);
    chk("R4 input 1 blocked", int'(grant_valid[1]), 0);
    step(2);
    chk("R5 released non-winner", int'(grant_valid[1]), 1);
    chk("R5 released port", int'(grant_port[1]), 5);
    step(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule